// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Pull-Up Control

This block is one bidirectional general-purpose I/O port for a small controller. It has eight pins. A simple register bus programs each pin. A direction register chooses, pin by pin, whether the pin drives or listens. A data register gives the value that a driving pin puts out. On a listening pin, a one in that same data bit turns on a weak pull-up. A shared pull-up-disable input overrides every pull-up at once.

Pad inputs reach the read path through a two-stage synchronizer. The first stage is a latch that is transparent while the clock is low. The second stage is a flop on the rising edge. A shared sleep input gates the pad values to zero ahead of the synchronizer, so floating pads cannot toggle internal logic while the chip sleeps.

Software reads and writes the three registers through a 2-bit address. Writing the input-register address does not store anything. Instead it is a toggle strobe: every one in the written data flips the matching data bit.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and right after it, `pad_oe`, `pad_out`, `pad_pu` and `rdata` are all zero. Every pin is then an input with no pull-up.
- R2: A write with `addr` = 1 loads the direction register from `wdata`. From the next clock edge, `pad_oe` equals the stored direction bits, where 1 means output. A read at address 1 returns them.
- R3: A write with `addr` = 2 loads the data register from `wdata`. From the next edge, `pad_out` equals it. A read at address 2 returns it.
- R4: A write with `addr` = 0 inverts each data-register bit whose `wdata` bit is 1. Data bits whose `wdata` bit is 0 keep their value.
- R5: `pad_pu` bit n is 1 exactly when direction bit n is 0, data bit n is 1 and `pud` is 0.
- R6: While `pud` is 1, every `pad_pu` bit is 0. `pud` has no effect on `pad_oe` or `pad_out`.
- R7: A read with `addr` = 0 returns the synchronized pad value. A pad level that is stable for two clock edges before the read edge is returned unchanged. This holds both for driven pins (loop-back) and for externally driven pins.
- R8: While `sleep` is 1, the synchronized pad value is forced to zero. A read at address 0 started two edges after `sleep` rises returns zero. After `sleep` falls, pad values return within two edges.
- R9: A read updates `rdata` at the clock edge where `rd_en` is sampled, which gives one cycle of latency. Without `rd_en`, `rdata` holds its value. A read and a write to the same address in the same cycle return the value from before the write.
- R10: Address 3 decodes to no register. Writes to it change nothing, and reads from it return zero.
- R11: Without `wr_en`, the direction and data registers hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 input/toggle, 1 direction, 2 data, 3 none |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pud | input | 1 | Global pull-up disable |
| sleep | input | 1 | Sleep gate for pad inputs |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The direction and data registers appear directly on `pad_oe` and `pad_out`. A wrong register bit or a wrong toggle therefore shows up one edge after the write that caused it.

A fault in the pull-up term shows on `pad_pu` in the same cycle as the register or `pud` change. The bench's pad model also feeds that fault back into the input path.

Synchronizer faults, such as a missing stage, a missed sleep gate or a wrong reset, only surface through a read at address 0. They appear at the earliest two edges after the pad change, plus the one-cycle read latency. The bench therefore reads the input register at exactly that distance after each pad or sleep change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;

  // Pull-up for one pin: only on a listening pin with its data bit set.
  function automatic logic pull_on(input logic dir_b, input logic data_b,
                                   input logic pud_b);
    return (!dir_b) && data_b && (!pud_b);
  endfunction

  // Next data-register bit for one pin, given the write strobes.
  function automatic logic data_next(input logic cur, input logic wbit,
                                     input logic load, input logic flip);
    logic nxt;
    nxt = cur;
    if (load)      nxt = wbit;
    else if (flip) nxt = cur ^ wbit;
    return nxt;
  endfunction

  // Next direction bit for one pin.
  function automatic logic dir_next(input logic cur, input logic wbit,
                                    input logic load);
    return load ? wbit : cur;
  endfunction

  // Pad value after sleep gating.
  function automatic logic gate_pad(input logic pad_b, input logic sleep_b);
    return pad_b && !sleep_b;
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_dir,
  input  logic             ld_data,
  input  logic             flip_data,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] data_q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic dir_d;
    logic data_d;

    always_comb begin
      dir_d  = dir_next(dir_q[i], wdata[i], ld_dir);
      data_d = data_next(data_q[i], wdata[i], ld_data, flip_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[i]  <= 1'b0;
        data_q[i] <= 1'b0;
      end else begin
        dir_q[i]  <= dir_d;
        data_q[i] <= data_d;
      end
    end
  end

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_sync
);

  logic [WIDTH-1:0] gated;
  logic [WIDTH-1:0] lat_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign gated[i] = gate_pad(pad_in[i], sleep);

    // First stage: transparent while the clock is low.
    always_latch begin
      if (!clk) lat_q[i] <= gated[i];
    end

    // Second stage: captures the latch on the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_sync[i] <= 1'b0;
      else        pin_sync[i] <= lat_q[i];
    end
  end

endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  input  logic             pud,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_oe[i]  = dir_q[i];
    assign pad_out[i] = data_q[i];
    assign pad_pu[i]  = pull_on(dir_q[i], data_q[i], pud);
  end

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] sel_val;

  always_comb begin
    case (addr)
      SEL_PIN:  sel_val = pin_sync;
      SEL_DIR:  sel_val = dir_q;
      SEL_DATA: sel_val = data_q;
      default:  sel_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel_val;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             pud,
  input  logic             sleep,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);

  // Decoded write strobes, common to all pins of the port.
  logic             wr_dir;
  logic             wr_data;
  logic             wr_pin;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] pin_sync;

  assign wr_dir  = wr_en && (addr == SEL_DIR);
  assign wr_data = wr_en && (addr == SEL_DATA);
  assign wr_pin  = wr_en && (addr == SEL_PIN);

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_dir    (wr_dir),
    .ld_data   (wr_data),
    .flip_data (wr_pin),
    .wdata     (wdata),
    .dir_q     (dir_q),
    .data_q    (data_q)
  );

  gpio_insync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .pad_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_padctl #(.WIDTH(WIDTH)) u_pad (
    .dir_q   (dir_q),
    .data_q  (data_q),
    .pud     (pud),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_pu  (pad_pu)
  );

  gpio_rdmux #(.WIDTH(WIDTH)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .pin_sync (pin_sync),
    .dir_q    (dir_q),
    .data_q   (data_q),
    .rdata    (rdata)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic             pud,
  input logic             sleep,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_pu,
  input logic [WIDTH-1:0] pin_sync,
  input logic             wr_dir,
  input logic             wr_pin
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert ((pad_oe | pad_out | pad_pu | rdata) == '0); // R1
    end
  end

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pad_oe == $past(wdata)); // R2

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> pad_out == $past(wdata)); // R3

  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin |=> pad_out == ($past(pad_out) ^ $past(wdata))); // R4

  AST_PULL_OFF_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0); // R5

  AST_PULL_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & ~pad_out) == '0); // R5

  AST_PUD_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    pud |-> pad_pu == '0); // R6

  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> pin_sync == '0); // R8

  AST_READ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1) |=> rdata == $past(pad_oe)); // R9

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R9

  AST_NONE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> rdata == '0); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pad_oe) && $stable(pad_out))); // R11

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .pud      (pud),
  .sleep    (sleep),
  .pad_oe   (pad_oe),
  .pad_out  (pad_out),
  .pad_pu   (pad_pu),
  .pin_sync (pin_sync),
  .wr_dir   (wr_dir),
  .wr_pin   (wr_pin)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         pud = 1'b0;
  logic         sleep = 1'b0;
  logic [W-1:0] pad_in;
  logic [W-1:0] pad_oe;
  logic [W-1:0] pad_out;
  logic [W-1:0] pad_pu;

  // Pad model: driven pins loop back, else an external driver, else the pull-up.
  logic [W-1:0] ext_en = '0;
  logic [W-1:0] ext_val = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pad_in[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : pad_pu[i]);
  end

  gpio_port #(.WIDTH(W)) u_gpio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pud(pud), .sleep(sleep), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pad_oe == 0, "R1 oe", pad_oe, 8'h00);
    check(pad_out == 0 && pad_pu == 0, "R1 out/pu", pad_out | pad_pu, 8'h00);
    check(rdata == 0, "R1 rdata", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check(pad_oe == 0 && pad_pu == 0, "R1 after release", pad_oe | pad_pu, 8'h00);
  endtask

  task automatic t_dir_data();
    logic [W-1:0] r;
    bus_write(2'd1, 8'h3C);
    check(pad_oe == 8'h3C, "R2 oe", pad_oe, 8'h3C);
    bus_read(2'd1, r);
    check(r == 8'h3C, "R2 readback", r, 8'h3C);
    bus_write(2'd2, 8'h96);
    check(pad_out == 8'h96, "R3 out", pad_out, 8'h96);
    bus_read(2'd2, r);
    check(r == 8'h96, "R3 readback", r, 8'h96);
  endtask

  task automatic t_toggle();
    bus_write(2'd2, 8'h0F);
    bus_write(2'd0, 8'h3C);
    check(pad_out == 8'h33, "R4 toggle ones", pad_out, 8'h33);
    bus_write(2'd0, 8'h00);
    check(pad_out == 8'h33, "R4 zeros no effect", pad_out, 8'h33);
    bus_write(2'd0, 8'hFF);
    check(pad_out == 8'hCC, "R4 toggle all", pad_out, 8'hCC);
  endtask

  task automatic t_pullup();
    logic [W-1:0] r;
    ext_en = '0;
    bus_write(2'd1, 8'h0F);
    bus_write(2'd2, 8'hFF);
    check(pad_pu == 8'hF0, "R5 pull on inputs", pad_pu, 8'hF0);
    bus_write(2'd2, 8'h5A);
    check(pad_pu == 8'h50, "R5 pull follows data", pad_pu, 8'h50);
    pud = 1'b1;
    #1;
    check(pad_pu == 8'h00, "R6 pud kills", pad_pu, 8'h00);
    check(pad_oe == 8'h0F && pad_out == 8'h5A, "R6 oe/out unchanged", pad_out, 8'h5A);
    idle(2);
    bus_read(2'd0, r);
    check(r == 8'h0A, "R6 floating inputs read low", r, 8'h0A);
    pud = 1'b0;
    idle(2);
    bus_read(2'd0, r);
    check(r == 8'h5A, "R5 pulled inputs read high", r, 8'h5A);
  endtask

  task automatic t_loopback();
    logic [W-1:0] r;
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'hA5);
    idle(2);
    bus_read(2'd0, r);
    check(r == 8'hA5, "R7 loopback", r, 8'hA5);
    bus_write(2'd1, 8'h00);
    bus_write(2'd2, 8'h00);
    ext_en = 8'hFF; ext_val = 8'h69;
    idle(2);
    bus_read(2'd0, r);
    check(r == 8'h69, "R7 external", r, 8'h69);
  endtask

  task automatic t_sleep();
    logic [W-1:0] r;
    ext_en = 8'hFF; ext_val = 8'hFF;
    sleep = 1'b1;
    idle(2);
    bus_read(2'd0, r);
    check(r == 8'h00, "R8 sleep reads zero", r, 8'h00);
    sleep = 1'b0;
    idle(2);
    bus_read(2'd0, r);
    check(r == 8'hFF, "R8 wake reads pads", r, 8'hFF);
  endtask

  task automatic t_read_timing();
    bus_write(2'd1, 8'h11);
    addr = 2'd1; wdata = 8'h22; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(rdata == 8'h11, "R9 read old on same-cycle write", rdata, 8'h11);
    check(pad_oe == 8'h22, "R9 write landed", pad_oe, 8'h22);
    addr = 2'd2;
    idle(3);
    check(rdata == 8'h11, "R9 rdata holds", rdata, 8'h11);
  endtask

  task automatic t_none_addr();
    logic [W-1:0] r;
    bus_write(2'd1, 8'h81);
    bus_write(2'd2, 8'h42);
    bus_write(2'd3, 8'hFF);
    check(pad_oe == 8'h81 && pad_out == 8'h42, "R10 write ignored", pad_out, 8'h42);
    bus_read(2'd3, r);
    check(r == 8'h00, "R10 read zero", r, 8'h00);
  endtask

  task automatic t_idle_hold();
    addr = 2'd0; wdata = 8'hFF; pud = 1'b1; sleep = 1'b1;
    idle(3);
    check(pad_oe == 8'h81, "R11 dir holds", pad_oe, 8'h81);
    check(pad_out == 8'h42, "R11 data holds", pad_out, 8'h42);
    pud = 1'b0; sleep = 1'b0;
  endtask

  initial begin
    t_reset();
    t_dir_data();
    t_toggle();
    t_pullup();
    t_loopback();
    t_sleep();
    t_read_timing();
    t_none_addr();
    t_idle_hold();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule